// File: doc/BRIEF.md
# Watchdog Timer Reset Controller

This block guards a small processor against firmware that has stopped running. A free-running timer counts microsecond enable pulses. One of its bits is picked as a slow tick, and that tick advances a two-bit watchdog counter. Firmware zeroes the counter by writing to a clear port, and the written data does not matter. If firmware fails to clear the counter in time, the counter's most significant bit rises. The block then drives a reset output for a fixed number of microsecond ticks.

A trip also leaves evidence and makes the USB side safe. It sets a sticky watchdog flag in bit 6 of a status register, and firmware clears that flag by writing a 0 to bit 6. It also wipes the USB device address register. The USB transmit enable follows the address-valid bit (bit 7) of that register. The transmitter therefore stays off until firmware writes an address with bit 7 set. The free-running timer keeps counting through a watchdog reset, so the time from a clear to a trip depends on where the clear falls within the timer period.

Top module: `wdr_ctrl`

## Requirements
- R1: The free-running timer advances once per cycle in which `us_en` is high. Only `por_n` clears it. A slow tick occurs on the enabled increment that takes timer bit `WDT_BIT` from 0 to 1, once every 2^(WDT_BIT+1) enabled ticks.
- R2: The watchdog counter advances by one on each slow tick. A trip occurs on the tick that takes the counter's MSB from 0 to 1. With the default 2-bit counter, this is the second slow tick after the counter was last zeroed.
- R3: A one-cycle pulse on `wd_clr` zeroes the watchdog counter. If the clear and a slow tick fall in the same cycle, the clear wins and the counter does not advance.
- R4: While `wd_rst` is high, the watchdog counter is held at zero, and slow ticks in that time do not count.
- R5: `wd_rst` rises in the cycle after a trip and stays high for exactly `PULSE_TICKS` enabled microsecond ticks. With `us_en` held high, that is `PULSE_TICKS` cycles.
- R6: A trip sets `stat_flag`, which then stays set across the reset pulse. `por_n` clears it.
- R7: A status write with bit 6 of `stat_wdata` at 0 clears `stat_flag`. A write with bit 6 at 1 leaves it unchanged. A trip in the same cycle as a clearing write leaves the flag set.
- R8: A trip clears the whole USB address register, so `usb_addr` reads 0 and `tx_en` reads 0. This holds even when an address write lands in the same cycle.
- R9: An address write stores bits 6:0 as `usb_addr` and bit 7 as `tx_en`. `tx_en` goes high only through a write with bit 7 set. Address writes made while `wd_rst` is high are ignored.
- R10: While `us_en` is low, neither the timer nor the watchdog counter advances, so no trip occurs.
- R11: After `por_n`, the outputs read `wd_rst` 0, `stat_flag` 0, `tx_en` 0 and `usb_addr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| us_en | input | 1 | One-cycle pulse per microsecond |
| wd_clr | input | 1 | Clear strobe for the watchdog counter (data ignored) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data; bit 6 = 0 clears the flag |
| addr_wr | input | 1 | USB address register write strobe |
| addr_wdata | input | 8 | Address write data; bits 6:0 address, bit 7 valid |
| stat_flag | output | 1 | Sticky watchdog-reset flag (status bit 6) |
| usb_addr | output | 7 | Stored USB device address |
| tx_en | output | 1 | USB transmit enable (address-valid bit) |
| wd_rst | output | 1 | Watchdog reset pulse |

## Verification
Two pairs of events can collide in one cycle. The first pair is a clear strobe and a slow tick. The bench provokes it by placing the clear at all sixteen phases of a shortened timer period, so one phase lands exactly on the tick. That case is judged by a trip that arrives one full period later than at the neighbouring phases. The second pair is a trip and a firmware write. The bench predicts the trip cycle arithmetically and issues a flag-clearing status write, or an address write with the valid bit set, in that cycle. It then requires the flag to stay set and the address to read zero.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  localparam int unsigned FLAG_BIT  = 6;
  localparam int unsigned VALID_BIT = 7;

  // True when the increment of v sets bit b that was clear before.
  function automatic logic bit_rises(input logic [31:0] v, input int unsigned b);
    logic [31:0] nxt;
    nxt = v + 32'd1;
    return !v[b] && nxt[b];
  endfunction

  // True on the last enabled tick of a pulse that lasts len ticks.
  function automatic logic pulse_last(input logic [31:0] cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/wdr_timebase.sv
module wdr_timebase #(
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned WDT_BIT = 11
) (
  input  logic clk,
  input  logic por_n,
  input  logic us_en,
  output logic slow_tick
);
  import wdr_pkg::*;

  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     tmr_q <= '0;
    else if (us_en) tmr_q <= tmr_q + 1'b1;
  end

  assign slow_tick = us_en && bit_rises(32'(tmr_q), WDT_BIT);

  // R1: the selected bit cannot rise on two enabled ticks in a row
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!por_n)
    slow_tick |=> !slow_tick);

endmodule

// File: rtl/wdr_wdcount.sv
module wdr_wdcount #(
  parameter int unsigned WD_W = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic trip_o
);
  import wdr_pkg::*;

  logic [WD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt_q <= '0;
    else if (clr_i || hold_i) cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + 1'b1;
  end

  assign trip_o = tick_i && !clr_i && !hold_i && bit_rises(32'(cnt_q), WD_W - 1);

  // R3: a cleared counter needs more than one tick to trip
  p_clear_blocks_trip_r3: assert property (@(posedge clk) disable iff (!por_n)
    clr_i |=> !trip_o);

  // R4: the counter is zero after any cycle spent in the reset pulse
  p_held_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
    hold_i |=> (cnt_q == '0));

  // R2: a trip leaves the MSB set
  p_msb_after_trip_r2: assert property (@(posedge clk) disable iff (!por_n)
    trip_o |=> cnt_q[WD_W-1]);

endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
  parameter int unsigned PULSE_TICKS = 2048
) (
  input  logic clk,
  input  logic por_n,
  input  logic us_en,
  input  logic trip_i,
  output logic rst_o
);
  import wdr_pkg::*;

  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] len_q;
  logic          active_q;
  logic          last_tick;

  assign last_tick = active_q && us_en && pulse_last(32'(len_q), PULSE_TICKS);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active_q <= 1'b0;
      len_q    <= '0;
    end else if (trip_i) begin
      active_q <= 1'b1;
      len_q    <= '0;
    end else if (last_tick) begin
      active_q <= 1'b0;
      len_q    <= '0;
    end else if (active_q && us_en) begin
      len_q    <= len_q + 1'b1;
    end
  end

  assign rst_o = active_q;

  // R5: the pulse starts the cycle after a trip
  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!por_n)
    trip_i |=> rst_o);

  // R5: the pulse holds while no enabled tick arrives
  p_pulse_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    (rst_o && !us_en) |=> rst_o);

endmodule

// File: rtl/wdr_ctrl.sv
module wdr_ctrl #(
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned WDT_BIT     = 11,
  parameter int unsigned WD_W        = 2,
  parameter int unsigned PULSE_TICKS = 2048
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       us_en,
  input  logic       wd_clr,
  input  logic       stat_wr,
  input  logic [7:0] stat_wdata,
  input  logic       addr_wr,
  input  logic [7:0] addr_wdata,
  output logic       stat_flag,
  output logic [6:0] usb_addr,
  output logic       tx_en,
  output logic       wd_rst
);
  import wdr_pkg::*;

  logic slow_tick;
  logic wd_trip;
  logic flag_q;
  logic [7:0] addr_q;
  logic stat_unused;

  assign stat_unused = ^{stat_wdata[7], stat_wdata[5:0]};

  wdr_timebase #(.TMR_W(TMR_W), .WDT_BIT(WDT_BIT)) u_tb (
    .clk(clk), .por_n(por_n), .us_en(us_en), .slow_tick(slow_tick));

  wdr_wdcount #(.WD_W(WD_W)) u_cnt (
    .clk(clk), .por_n(por_n), .tick_i(slow_tick), .clr_i(wd_clr),
    .hold_i(wd_rst), .trip_o(wd_trip));

  wdr_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .por_n(por_n), .us_en(us_en), .trip_i(wd_trip), .rst_o(wd_rst));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                flag_q <= 1'b0;
    else if (wd_trip)                          flag_q <= 1'b1;
    else if (stat_wr && !stat_wdata[FLAG_BIT]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 addr_q <= '0;
    else if (wd_trip)           addr_q <= '0;
    else if (addr_wr && !wd_rst) addr_q <= addr_wdata;
  end

  assign stat_flag = flag_q;
  assign usb_addr  = addr_q[6:0];
  assign tx_en     = addr_q[VALID_BIT];

  // R6: a trip always leaves the flag set
  p_flag_on_trip_r6: assert property (@(posedge clk) disable iff (!por_n)
    wd_trip |=> stat_flag);

  // R8: a trip leaves the address register empty
  p_addr_wiped_r8: assert property (@(posedge clk) disable iff (!por_n)
    wd_trip |=> (!tx_en && usb_addr == 7'd0));

  // R9: transmit enable rises only from a valid address write
  p_txen_by_write_r9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(tx_en) |-> $past(addr_wr && addr_wdata[VALID_BIT] && !wd_rst));

  // R4: no new trip while the pulse is running
  p_no_retrigger_r4: assert property (@(posedge clk) disable iff (!por_n)
    wd_rst |-> !wd_trip);

endmodule

// File: tb/wdr_ctrl_tb_top.sv
module wdr_ctrl_tb_top;
  localparam int TW = 8, WB = 3, PL = 20;
  localparam int PER = 1 << (WB + 1);
  localparam int HALF = 1 << WB;

  logic clk = 0, por_n = 0, us_en = 0, wd_clr = 0, stat_wr = 0, addr_wr = 0;
  logic [7:0] stat_wdata = 0, addr_wdata = 0;
  logic stat_flag, tx_en, wd_rst;
  logic [6:0] usb_addr;

  wdr_ctrl #(.TMR_W(TW), .WDT_BIT(WB), .WD_W(2), .PULSE_TICKS(PL)) dut_i (
    .clk(clk), .por_n(por_n), .us_en(us_en), .wd_clr(wd_clr),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .addr_wr(addr_wr),
    .addr_wdata(addr_wdata), .stat_flag(stat_flag), .usb_addr(usb_addr),
    .tx_en(tx_en), .wd_rst(wd_rst));

  always #5 clk = ~clk;

  // Bench view of the timer: number of enabled edges since reset.
  int tmr_model = 0;
  always @(posedge clk) if (!por_n) tmr_model <= 0; else if (us_en) tmr_model <= tmr_model + 1;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Second slow tick strictly after edge m (counter zeroed at edge m).
  function automatic int trip_edge(input int m);
    int t1;
    t1 = m + 1 + ((HALF - ((m + 1) % PER)) + PER) % PER;
    return t1 + PER;
  endfunction

  task automatic measure_pulse();
    int n = 0;
    while (wd_rst && n < 4 * PL) begin
      n++;
      addr_wr = (n == 2); addr_wdata = 8'h81;
      stat_wr = (n == 3); stat_wdata = 8'h40;
      @(negedge clk);
    end
    addr_wr = 0; stat_wr = 0;
    chk(n == PL, "R5", "pulse length", n, PL);
    chk(tx_en == 0, "R9", "write during pulse ignored", tx_en, 0);
    chk(stat_flag == 1, "R7", "bit6=1 write keeps flag", stat_flag, 1);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int r, m, n2, exp_tag;
    string tag;
    repeat (3) @(negedge clk);
    por_n = 1; us_en = 1;
    chk(wd_rst == 0, "R11", "reset wd_rst", wd_rst, 0);
    chk(stat_flag == 0, "R11", "reset flag", stat_flag, 0);
    chk(tx_en == 0, "R11", "reset tx_en", tx_en, 0);
    chk(usb_addr == 0, "R11", "reset addr", usb_addr, 0);

    addr_wr = 1; addr_wdata = 8'h05; @(negedge clk); addr_wr = 0;
    chk(usb_addr == 5 && tx_en == 0, "R9", "address without valid", {tx_en, usb_addr}, 5);
    addr_wr = 1; addr_wdata = 8'h85; @(negedge clk); addr_wr = 0;
    chk(tx_en == 1 && usb_addr == 5, "R9", "address with valid", {tx_en, usb_addr}, 8'h85);

    // First trip from power-on: counter zeroed at edge 0.
    n2 = trip_edge(0);
    while (!wd_rst && tmr_model <= n2 + 2) @(negedge clk);
    chk(tmr_model == n2, "R1 R2", "trip edge after power-on", tmr_model, n2);
    chk(stat_flag == 1, "R6", "flag after trip", stat_flag, 1);
    chk(tx_en == 0 && usb_addr == 0, "R8", "address wiped", {tx_en, usb_addr}, 0);
    measure_pulse();
    r = tmr_model;

    // Sweep the clear over every phase of the timer period; d = 0 means no clear.
    for (int d = 0; d <= PER; d++) begin
      m  = (d == 0) ? r : r + d;
      n2 = trip_edge(m);
      while (!wd_rst && tmr_model <= n2 + 2) begin
        int e;
        if (tmr_model == r + 1) begin
          chk(stat_flag == 0, "R7", "bit6=0 write clears flag", stat_flag, 0);
          chk(tx_en == 1, "R9", "valid address re-written", tx_en, 1);
        end
        e = tmr_model + 1;
        wd_clr     = (d != 0) && (e == m);
        stat_wr    = (e == r + 1) || (d == 5 && e == n2);
        stat_wdata = 8'h00;
        addr_wr    = (e == r + 1) || (d == 6 && e == n2);
        addr_wdata = (e == r + 1) ? 8'h83 : 8'h8A;
        @(negedge clk);
      end
      wd_clr = 0; stat_wr = 0; addr_wr = 0;
      exp_tag = (d != 0 && (m % PER) == HALF) ? 1 : 0;
      tag = (d == 0) ? "R4" : (exp_tag == 1 ? "R3" : "R1 R2");
      chk(tmr_model == n2, tag, $sformatf("trip edge, clear offset %0d", d), tmr_model, n2);
      chk(stat_flag == 1, (d == 5) ? "R7" : "R6", "flag set by trip", stat_flag, 1);
      chk(tx_en == 0 && usb_addr == 0, "R8", "address wiped by trip", {tx_en, usb_addr}, 0);
      measure_pulse();
      r = tmr_model;
    end

    // Enable held low: nothing advances.
    begin
      int seen = 0;
      us_en = 0;
      repeat (4 * PER) begin
        @(negedge clk);
        if (wd_rst) seen++;
      end
      chk(seen == 0, "R10", "no trip with enable low", seen, 0);
    end

    summary();
    $finish;
  end
endmodule